// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the word address for each beat of a four-beat burst in a synchronous burst memory. A cycle starts when one of two active-low address strobes is sampled low at a clock edge. The block then captures the external address. The upper bits are held for the whole burst. The two low-order bits come from a beat counter and the captured start offset, and they are combined in one of two orders.

The processor strobe can start a cycle only while the chip-enable input is high. The controller strobe starts a cycle regardless of chip enable. When neither strobe is active, a low advance input moves the burst on by one beat, and a high advance input holds the current beat as a wait state. A static order input selects linear order (the offset counts up modulo four from the start) or interleaved order (the offset is the start XOR the beat number). The burst has no end: after the fourth beat the offset returns to its start value.

Top module: `burst_addr_seq`

## Requirements
- R1: On a rising clock edge where `proc_strb_n` is 0 and `chip_en` is 1, `addr_out` becomes the `addr_in` value of that edge, and `beat_ofs` becomes `addr_in[1:0]`.
- R2: On an edge where `proc_strb_n` is 0, `chip_en` is 0 and `ctrl_strb_n` is 1, no load happens. The address and offset are held or advanced exactly as if `proc_strb_n` were 1.
- R3: On an edge where `ctrl_strb_n` is 0, the external address is loaded as in R1, whatever the value of `chip_en`.
- R4: On an edge with no load and `adv_n` 0, the beat number advances by one.
- R5: On an edge with no load and `adv_n` 1, `addr_out` and `beat_ofs` keep their values.
- R6: With `ilv_mode` 0, the offset at beat k is (start + k) mod 4. For example, a start of 01 gives 01, 10, 11, 00.
- R7: With `ilv_mode` 1, the offset at beat k is start XOR k. A start of 01 gives 01, 00, 11, 10, and a start of 11 gives 11, 10, 01, 00.
- R8: `addr_out[ADDR_W-1:2]` stays at the loaded upper bits while the burst advances or holds. Only bits [1:0] follow the beat offset.
- R9: A load on an edge where `adv_n` is 0 takes priority over advancing, and the burst restarts at beat 0 of the new address.
- R10: After four advances the offset is back at the start value, and the sequence keeps cycling without stopping.
- R11: While `rst_n` is 0, `addr_out` and `beat_ofs` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W | External word address |
| proc_strb_n | input | 1 | Processor address strobe, active low, qualified by chip_en |
| ctrl_strb_n | input | 1 | Controller address strobe, active low, unqualified |
| chip_en | input | 1 | Chip selected (1) |
| adv_n | input | 1 | Burst advance, active low |
| ilv_mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current burst word address |
| beat_ofs | output | 2 | Current two-bit burst offset |

## Verification
Bursts are run from start offsets 01 and 11 in both orders. Linear and interleaved sequences agree on some beats and differ on others, so a swapped or mixed-up order shows up at those beats. Each strobe is tried with chip enable high and low, which separates the gated processor path from the free controller path. Rejected strobes are given with advance both high and low, so an ignored strobe cannot hide behind a hold. Wait states are placed inside bursts, and a new load arrives on an edge that also carries an advance. A full wrap of four beats is run, and the upper address bits are compared on every beat to catch any carry out of the counter.

// File: rtl/bas_pkg.sv
package bas_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_XOR = 1'b1} order_e;

  // Offset for beat number k, given the start offset and the order.
  function automatic beat_t map_beat(order_e ord, beat_t start, beat_t k);
    beat_t r;
    if (ord == ORD_XOR) r = start ^ k;
    else                r = beat_t'(start + k);
    return r;
  endfunction
endpackage

// File: rtl/bas_load_ctl.sv
module bas_load_ctl #(
  parameter bit CTRL_GATED = 1'b0
) (
  input  logic proc_strb_n,
  input  logic ctrl_strb_n,
  input  logic chip_en,
  input  logic adv_n,
  output logic load_en,
  output logic step_en
);
  logic proc_hit;
  logic ctrl_hit;

  // The processor strobe counts only while the chip is selected.
  assign proc_hit = ~proc_strb_n & chip_en;

  generate
    if (CTRL_GATED) begin : g_ctrl_gated
      assign ctrl_hit = ~ctrl_strb_n & chip_en;
    end else begin : g_ctrl_free
      assign ctrl_hit = ~ctrl_strb_n;
    end
  endgenerate

  // A load overrides advance (R9).
  assign load_en = proc_hit | ctrl_hit;
  assign step_en = ~load_en & ~adv_n;
endmodule

// File: rtl/bas_beat_cnt.sv
module bas_beat_cnt
  import bas_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_en,
  input  logic  step_en,
  output beat_t k_q
);
  beat_t k_d;
  logic  k_en;

  always_comb begin
    k_en = load_en | step_en;
    if (load_en) k_d = '0;
    else         k_d = beat_t'(k_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    k_q <= '0;
    else if (k_en) k_q <= k_d;
  end

  // R4 / R10: each advance moves the beat number on by one, modulo four
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> k_q == beat_t'($past(k_q) + 1'b1));
  // R5: the beat number is held when there is neither a load nor an advance
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !step_en) |=> $stable(k_q));
  // R9: a load restarts the burst at beat zero
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> k_q == '0);
endmodule

// File: rtl/bas_addr_reg.sv
module bas_addr_reg
  import bas_pkg::*;
#(
  parameter int ADDR_W = 18,
  localparam int UP_W = ADDR_W - BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [UP_W-1:0]   up_q,
  output beat_t             start_q
);
  logic [UP_W-1:0] up_d;
  beat_t           start_d;

  always_comb begin
    up_d    = addr_in[ADDR_W-1:BEAT_W];
    start_d = addr_in[BEAT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q    <= '0;
      start_q <= '0;
    end else if (load_en) begin
      up_q    <= up_d;
      start_q <= start_d;
    end
  end

  // R8: the upper bits change only on a load
  a_r8_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(up_q) && $stable(start_q));
endmodule

// File: rtl/bas_ofs_map.sv
module bas_ofs_map
  import bas_pkg::*;
(
  input  order_e ord,
  input  beat_t  start,
  input  beat_t  k,
  output beat_t  ofs
);
  always_comb ofs = map_beat(ord, start, k);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter bit CTRL_GATED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              proc_strb_n,
  input  logic              ctrl_strb_n,
  input  logic              chip_en,
  input  logic              adv_n,
  input  logic              ilv_mode,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        beat_ofs
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic            load_en;
  logic            step_en;
  logic [UP_W-1:0] up_q;
  beat_t           start_q;
  beat_t           k_q;
  beat_t           ofs;

  bas_load_ctl #(.CTRL_GATED(CTRL_GATED)) u_ctl (
    .proc_strb_n (proc_strb_n),
    .ctrl_strb_n (ctrl_strb_n),
    .chip_en     (chip_en),
    .adv_n       (adv_n),
    .load_en     (load_en),
    .step_en     (step_en)
  );

  bas_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .addr_in (addr_in),
    .up_q    (up_q),
    .start_q (start_q)
  );

  bas_beat_cnt u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .step_en (step_en),
    .k_q     (k_q)
  );

  bas_ofs_map u_map (
    .ord   (order_e'(ilv_mode)),
    .start (start_q),
    .k     (k_q),
    .ofs   (ofs)
  );

  assign addr_out = {up_q, ofs};
  assign beat_ofs = ofs;

  generate
    if (!CTRL_GATED) begin : g_port_chk
      // R1 / R3: a strobe that is accepted loads the external address
      a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_strb_n || (!proc_strb_n && chip_en)) |=> addr_out == $past(addr_in));
      // R2: a processor strobe while deselected does not load
      a_r2_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strb_n && !chip_en && ctrl_strb_n && adv_n) |=> $stable({up_q, start_q, k_q}));
    end
  endgenerate

  // R6: in linear order each advance adds one to the offset
  a_r6_linear: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !ilv_mode) |=> (ilv_mode || beat_ofs == beat_t'($past(beat_ofs) + 1'b1)));
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          proc_strb_n = 1'b1;
  logic          ctrl_strb_n = 1'b1;
  logic          chip_en = 1'b0;
  logic          adv_n = 1'b1;
  logic          ilv_mode = 1'b0;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat_ofs;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [AW-1:0] exp_q[$];
  string         tag_q[$];

  // Expected state of the block, derived from the requirements.
  logic [AW-3:0] m_up = '0;
  logic [1:0]    m_start = '0;
  logic [1:0]    m_k = '0;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .proc_strb_n(proc_strb_n),
    .ctrl_strb_n(ctrl_strb_n), .chip_en(chip_en), .adv_n(adv_n),
    .ilv_mode(ilv_mode), .addr_out(addr_out), .beat_ofs(beat_ofs)
  );

  // Driver: drive one cycle of inputs and queue the expected address.
  task automatic cyc(input logic [AW-1:0] a, input logic p_n, input logic c_n,
                     input logic ce, input logic a_n, input string tag);
    logic [1:0] ofs;
    @(negedge clk);
    addr_in = a; proc_strb_n = p_n; ctrl_strb_n = c_n; chip_en = ce; adv_n = a_n;
    if (!c_n || (!p_n && ce)) begin
      m_up = a[AW-1:2]; m_start = a[1:0]; m_k = 2'd0;
    end else if (!a_n) begin
      m_k = m_k + 2'd1;
    end
    ofs = ilv_mode ? (m_start ^ m_k) : (m_start + m_k);
    exp_q.push_back({m_up, ofs});
    tag_q.push_back(tag);
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    ilv_mode = m; proc_strb_n = 1'b1; ctrl_strb_n = 1'b1; adv_n = 1'b1;
  endtask

  // Monitor: compare after each rising edge, away from the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [AW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (addr_out !== e || beat_ofs !== e[1:0]) begin
          bad++;
          $display("FAIL %s: addr_out=%h beat_ofs=%b expected addr=%h ofs=%b",
                   t, addr_out, beat_ofs, e, e[1:0]);
        end
      end
    end
  end

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (addr_out !== '0 || beat_ofs !== 2'b00) begin
      bad++;
      $display("FAIL R11: addr_out=%h beat_ofs=%b expected 0 0", addr_out, beat_ofs);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // Linear order, start offset 01, processor strobe with chip selected
    cyc(18'h12345, 1'b0, 1'b1, 1'b1, 1'b1, "R1 proc load");
    cyc(18'h00000, 1'b1, 1'b1, 1'b1, 1'b0, "R6 linear beat1");
    cyc(18'h00000, 1'b1, 1'b1, 1'b1, 1'b1, "R5 wait state");
    cyc(18'h00000, 1'b1, 1'b1, 1'b1, 1'b0, "R6 linear beat2");
    cyc(18'h3FFFF, 1'b1, 1'b1, 1'b0, 1'b0, "R8 upper kept beat3");
    cyc(18'h00000, 1'b1, 1'b1, 1'b1, 1'b0, "R10 wrap to start");
    cyc(18'h00000, 1'b1, 1'b1, 1'b1, 1'b0, "R10 keeps cycling");
    // Deselected processor strobe
    cyc(18'h2AAAA, 1'b0, 1'b1, 1'b0, 1'b1, "R2 ignored hold");
    cyc(18'h2AAAA, 1'b0, 1'b1, 1'b0, 1'b0, "R2 ignored advance");
    // Controller strobe, deselected
    cyc(18'h1F0F3, 1'b1, 1'b0, 1'b0, 1'b1, "R3 ctrl load deselected");
    cyc(18'h00000, 1'b1, 1'b1, 1'b0, 1'b0, "R6 linear from 11");
    cyc(18'h00000, 1'b1, 1'b1, 1'b0, 1'b1, "R5 hold");
    // Load during a burst with advance low
    cyc(18'h04442, 1'b1, 1'b0, 1'b1, 1'b0, "R9 ctrl load wins");
    cyc(18'h00000, 1'b1, 1'b1, 1'b1, 1'b0, "R9 restart beat1");
    cyc(18'h08881, 1'b0, 1'b1, 1'b1, 1'b0, "R9 proc load wins");

    // Interleaved order
    set_mode(1'b1);
    cyc(18'h0ABC1, 1'b0, 1'b1, 1'b1, 1'b1, "R7 xor start 01");
    cyc(18'h00000, 1'b1, 1'b1, 1'b1, 1'b0, "R7 xor beat1");
    cyc(18'h00000, 1'b1, 1'b1, 1'b1, 1'b0, "R7 xor beat2");
    cyc(18'h00000, 1'b1, 1'b1, 1'b1, 1'b1, "R5 xor hold");
    cyc(18'h00000, 1'b1, 1'b1, 1'b1, 1'b0, "R7 xor beat3");
    cyc(18'h00000, 1'b1, 1'b1, 1'b1, 1'b0, "R10 xor wrap");
    cyc(18'h33337, 1'b1, 1'b0, 1'b1, 1'b1, "R3 ctrl load start 11");
    for (int i = 0; i < 3; i++)
      cyc(18'h00000, 1'b1, 1'b1, 1'b1, 1'b0, "R7 xor from 11");
    cyc(18'h15552, 1'b0, 1'b1, 1'b0, 1'b0, "R2 ignored xor advance");
    cyc(18'h00000, 1'b1, 1'b1, 1'b1, 1'b0, "R8 upper after xor wrap");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule